// File: doc/BRIEF.md
# Compare-and-Capture Interval Timer

This block is an up-counting interval timer meant to sit behind a simple peripheral register port. A functional tick enable paces the count, optionally slowed by a power-of-two prescaler. When the count passes its all-ones value it either reloads from a programmable load value and keeps running, or wraps to zero and stops itself. A match register is compared against each new count value, and a write to a dedicated trigger register restarts the count from the load value.

An input pin is synchronised and edge-detected. The count is captured on the chosen edges, either into one capture register every time or into two registers for the first and second edge. Overflow and match events can drive an output pin, which either toggles or emits a pulse one functional tick wide. While the timer is stopped the pin rests at a programmable idle level. Match, overflow and capture are reported as single-cycle event pulses for an interrupt status block.

Register select codes on `wr_addr` and `rd_addr`: 0 control, 1 count, 2 load, 3 trigger (write only), 4 match, 5 first capture, 6 second capture (5 and 6 are read only). Control fields: bit 0 run, bit 1 reload enable, bits [4:2] prescale value, bit 5 prescale enable, bit 6 compare enable, bit 7 idle level, bits [9:8] capture edge, bits [11:10] output trigger source, bit 12 toggle select, bit 13 dual capture. Event bits: 0 match, 1 overflow, 2 capture.

Top module: `cmpcap_timer`

## Requirements
- R1: After synchronous reset, every register reads 0, `evt_o` is 0 and `pwm_o` is 0.
- R2: With run set (control bit 0) and prescaling off, the count rises by one at each clock edge where `tick_i` is high. After run is cleared, the count holds from the edge that follows the write, well inside four ticks.
- R3: When the count steps from all ones with reload enabled (bit 1), it takes the load value and `evt_o[1]` pulses. Without reload it wraps to 0, `evt_o[1]` pulses and the run bit clears itself.
- R4: With prescaling enabled (bit 5), the count advances once per 2^(p+1) ticks, where p is the value in bits [4:2].
- R5: With compare enabled (bit 6), `evt_o[0]` pulses in the cycle the count steps onto the match value. With compare disabled, no match event occurs.
- R6: Any write to the trigger register loads the count from the load register, whatever data is written.
- R7: Bits [9:8] choose the capture edge: 0 none, 1 rising, 2 falling, 3 both. On a chosen edge the count is stored in the first capture register and `evt_o[2]` pulses three clock edges after the pin changes.
- R8: With bit 13 set, the first chosen edge fills the first capture register and the second fills the second. Later edges are ignored until the control register is written again.
- R9: Bits [11:10] pick the output trigger: 0 none, 1 overflow, 2 overflow or match. With bit 12 set, `pwm_o` inverts on each trigger in the same cycle as the event.
- R10: With bit 12 clear, a trigger drives `pwm_o` to the inverse of the idle level, and it returns to the idle level at the next tick.
- R11: While run is clear, `pwm_o` follows the idle level (bit 7) one cycle after it is written.
- R12: `rd_data` presents the register selected by `rd_addr` one clock edge after the select is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Functional tick enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write register select |
| wr_data | input | W | Write data |
| rd_addr | input | 3 | Read register select |
| rd_data | output | W | Registered read data |
| cap_pin_i | input | 1 | Asynchronous capture input |
| evt_o | output | 3 | Event pulses: match, overflow, capture |
| pwm_o | output | 1 | Timer output pin |

## Verification
A register write takes effect at the clock edge that samples it. The count, match and overflow events and the output pin all change at the edge where a tick is applied. A capture lands three edges after the pin moves, and read data arrives one edge after the select. The bench drives and samples on the falling edge and gates `tick_i` so that an exact number of ticks is applied before a check. Each event or pin check is placed at the falling edge that directly follows its due edge, and the count is read back only while ticks are held off, so the value cannot move during the one-cycle read.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [2:0] {
    SEL_CTRL  = 3'd0,
    SEL_COUNT = 3'd1,
    SEL_LOAD  = 3'd2,
    SEL_TRIG  = 3'd3,
    SEL_MATCH = 3'd4,
    SEL_CAP1  = 3'd5,
    SEL_CAP2  = 3'd6
  } reg_sel_e;

  localparam int CTRL_W     = 14;
  localparam int PTV_W      = 3;
  localparam int CB_RUN     = 0;
  localparam int CB_RELOAD  = 1;
  localparam int CB_PTV_LO  = 2;
  localparam int CB_PRE_EN  = 5;
  localparam int CB_CMP_EN  = 6;
  localparam int CB_IDLE    = 7;
  localparam int CB_EDGE_LO = 8;
  localparam int CB_TRIG_LO = 10;
  localparam int CB_TOGGLE  = 12;
  localparam int CB_DUAL    = 13;

  localparam int EVT_N     = 3;
  localparam int EVT_MATCH = 0;
  localparam int EVT_OVF   = 1;
  localparam int EVT_CAP   = 2;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PTV_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             pre_en,
  input  logic             tick,
  input  logic [PTV_W-1:0] ptv,
  output logic             step
);
  localparam int PCW = 1 << PTV_W;

  logic [PCW-1:0] pcnt_q;
  logic [PCW-1:0] lim;

  // divide ratio 2^(ptv+1): terminal count is that minus one
  assign lim  = (PCW'(2) << ptv) - PCW'(1);
  assign step = tick && (!pre_en || (pcnt_q == lim));

  always_ff @(posedge clk) begin
    if (rst || !run || !pre_en) begin
      pcnt_q <= '0;
    end else if (tick) begin
      pcnt_q <= (pcnt_q == lim) ? '0 : pcnt_q + PCW'(1);
    end
  end
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture #(
  parameter int W    = 32,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         pin,
  input  logic [1:0]   edge_sel,
  input  logic         dual,
  input  logic         rearm,
  input  logic [W-1:0] count,
  output logic [W-1:0] cap1,
  output logic [W-1:0] cap2,
  output logic         cap_evt
);
  logic [SYNC-1:0] sync_q;
  logic            prev_q;
  logic [1:0]      seen_q;
  logic            rise, fall, hit;

  always_ff @(posedge clk) begin
    if (rst) sync_q[0] <= 1'b0;
    else     sync_q[0] <= pin;
  end

  for (genvar i = 1; i < SYNC; i++) begin : g_sync
    always_ff @(posedge clk) begin
      if (rst) sync_q[i] <= 1'b0;
      else     sync_q[i] <= sync_q[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_q[SYNC-1];
  end

  assign rise = sync_q[SYNC-1] && !prev_q;
  assign fall = !sync_q[SYNC-1] && prev_q;

  always_comb begin
    unique case (edge_sel)
      2'd1:    hit = rise;
      2'd2:    hit = fall;
      2'd3:    hit = rise || fall;
      default: hit = 1'b0;
    endcase
  end

  assign cap_evt = hit && !rearm && (!dual || (seen_q != 2'd2));

  always_ff @(posedge clk) begin
    if (rst) begin
      cap1   <= '0;
      cap2   <= '0;
      seen_q <= 2'd0;
    end else if (rearm) begin
      seen_q <= 2'd0;
    end else if (cap_evt) begin
      if (!dual || seen_q == 2'd0) begin
        cap1 <= count;
        if (dual) seen_q <= 2'd1;
      end else begin
        cap2   <= count;
        seen_q <= 2'd2;
      end
    end
  end
endmodule

// File: rtl/tmr_outpin.sv
module tmr_outpin (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       tick,
  input  logic       idle_lvl,
  input  logic       toggle,
  input  logic [1:0] trig_sel,
  input  logic       ovf_hit,
  input  logic       match_hit,
  output logic       pin_o
);
  logic trig;

  always_comb begin
    unique case (trig_sel)
      2'd1:    trig = ovf_hit;
      2'd2:    trig = ovf_hit || match_hit;
      default: trig = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_o <= 1'b0;
    end else if (!run) begin
      pin_o <= idle_lvl;
    end else if (toggle) begin
      if (trig) pin_o <= !pin_o;
    end else if (trig) begin
      pin_o <= !idle_lvl;
    end else if (tick) begin
      pin_o <= idle_lvl;
    end
  end
endmodule

// File: rtl/cmpcap_timer.sv
module cmpcap_timer
  import tmr_pkg::*;
#(
  parameter int W    = 32,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_i,
  input  logic         wr_en,
  input  logic [2:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic [2:0]   rd_addr,
  output logic [W-1:0] rd_data,
  input  logic         cap_pin_i,
  output logic [EVT_N-1:0] evt_o,
  output logic         pwm_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [W-1:0]      count_q, load_q, match_q, cap1_q, cap2_q, rd_q, nxt;
  logic [EVT_N-1:0]  evt_q;
  logic wr_ctrl, wr_count, wr_load, wr_trig, wr_match;
  logic run, reload, step, adv, at_top, ovf_hit, match_hit, cap_evt;

  assign wr_ctrl  = wr_en && (wr_addr == SEL_CTRL);
  assign wr_count = wr_en && (wr_addr == SEL_COUNT);
  assign wr_load  = wr_en && (wr_addr == SEL_LOAD);
  assign wr_trig  = wr_en && (wr_addr == SEL_TRIG);
  assign wr_match = wr_en && (wr_addr == SEL_MATCH);

  assign run    = ctrl_q[CB_RUN];
  assign reload = ctrl_q[CB_RELOAD];

  tmr_prescaler #(.PTV_W(PTV_W)) u_pre (
    .clk    (clk),
    .rst    (rst),
    .run    (run),
    .pre_en (ctrl_q[CB_PRE_EN]),
    .tick   (tick_i),
    .ptv    (ctrl_q[CB_PTV_LO +: PTV_W]),
    .step   (step)
  );

  assign adv       = run && step;
  assign at_top    = (count_q == '1);
  assign nxt       = at_top ? (reload ? load_q : '0) : count_q + W'(1);
  assign ovf_hit   = adv && at_top;
  assign match_hit = adv && ctrl_q[CB_CMP_EN] && (nxt == match_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q <= wr_data[CTRL_W-1:0];
    end else if (ovf_hit && !reload) begin
      ctrl_q[CB_RUN] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      load_q  <= '0;
      match_q <= '0;
    end else begin
      if (wr_load)  load_q  <= wr_data;
      if (wr_match) match_q <= wr_data;
      if (wr_count)     count_q <= wr_data;
      else if (wr_trig) count_q <= load_q;
      else if (adv)     count_q <= nxt;
    end
  end

  tmr_capture #(.W(W), .SYNC(SYNC)) u_cap (
    .clk      (clk),
    .rst      (rst),
    .pin      (cap_pin_i),
    .edge_sel (ctrl_q[CB_EDGE_LO +: 2]),
    .dual     (ctrl_q[CB_DUAL]),
    .rearm    (wr_ctrl),
    .count    (count_q),
    .cap1     (cap1_q),
    .cap2     (cap2_q),
    .cap_evt  (cap_evt)
  );

  tmr_outpin u_out (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .tick      (tick_i),
    .idle_lvl  (ctrl_q[CB_IDLE]),
    .toggle    (ctrl_q[CB_TOGGLE]),
    .trig_sel  (ctrl_q[CB_TRIG_LO +: 2]),
    .ovf_hit   (ovf_hit),
    .match_hit (match_hit),
    .pin_o     (pwm_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_q <= '0;
    end else begin
      evt_q[EVT_MATCH] <= match_hit;
      evt_q[EVT_OVF]   <= ovf_hit;
      evt_q[EVT_CAP]   <= cap_evt;
    end
  end
  assign evt_o = evt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else begin
      unique case (reg_sel_e'(rd_addr))
        SEL_CTRL:  rd_q <= W'(ctrl_q);
        SEL_COUNT: rd_q <= count_q;
        SEL_LOAD:  rd_q <= load_q;
        SEL_MATCH: rd_q <= match_q;
        SEL_CAP1:  rd_q <= cap1_q;
        SEL_CAP2:  rd_q <= cap2_q;
        default:   rd_q <= '0;
      endcase
    end
  end
  assign rd_data = rd_q;
endmodule

// File: rtl/cmpcap_timer_chk.sv
module cmpcap_timer_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         wr_en,
  input logic [2:0]   evt_o,
  input logic         pwm_o,
  input logic [13:0]  ctrl_q,
  input logic [W-1:0] count_q,
  input logic [W-1:0] match_q,
  input logic [W-1:0] cap1_q,
  input logic [W-1:0] cap2_q
);
  a_r2_hold_when_stopped: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q[0] && !wr_en) |=> $stable(count_q));

  a_r3_overflow_from_top: assert property (@(posedge clk) disable iff (rst)
    evt_o[1] |-> ($past(count_q) == '1));

  a_r5_match_value: assert property (@(posedge clk) disable iff (rst)
    evt_o[0] |-> (count_q == $past(match_q)));

  a_r7_capture_value: assert property (@(posedge clk) disable iff (rst)
    evt_o[2] |-> ((cap1_q == $past(count_q)) || (cap2_q == $past(count_q))));

  a_r11_idle_level: assert property (@(posedge clk) disable iff (rst)
    $past(!ctrl_q[0]) |-> (pwm_o == $past(ctrl_q[7])));
endmodule

bind cmpcap_timer cmpcap_timer_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .evt_o   (evt_o),
  .pwm_o   (pwm_o),
  .ctrl_q  (ctrl_q),
  .count_q (count_q),
  .match_q (match_q),
  .cap1_q  (cap1_q),
  .cap2_q  (cap2_q)
);

// File: tb/cmpcap_timer_bench.sv
module cmpcap_timer_bench;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         tick_i = 1'b0;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [2:0]   rd_addr = '0;
  logic [W-1:0] rd_data;
  logic         cap_pin_i = 1'b0;
  logic [2:0]   evt_o;
  logic         pwm_o;

  int n_chk = 0;
  int n_fail = 0;
  int n_match = 0;
  int n_ovf = 0;
  int n_cap = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cmpcap_timer #(.W(W)) u_cmpcap_timer (
    .clk(clk), .rst(rst), .tick_i(tick_i), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .cap_pin_i(cap_pin_i), .evt_o(evt_o), .pwm_o(pwm_o)
  );

  always @(posedge clk) begin
    if (evt_o[0]) n_match++;
    if (evt_o[1]) n_ovf++;
    if (evt_o[2]) n_cap++;
  end

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [W-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [W-1:0] d);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic ticks(input int n);
    tick_i = 1'b1;
    repeat (n) @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic pin_to(input logic v);
    cap_pin_i = v;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [W-1:0] d;
    for (int a = 0; a < 7; a++) begin
      reg_rd(3'(a), d);
      check("R1 register after reset", d, '0);
    end
    check("R1 evt after reset", W'(evt_o), '0);
    check("R1 pwm after reset", W'(pwm_o), '0);
  endtask

  task automatic t_count_stop();
    logic [W-1:0] d, d2;
    reg_wr(3'd1, 32'd0);
    reg_wr(3'd0, 32'h1);
    ticks(7);
    reg_rd(3'd1, d);
    check("R2 count after 7 ticks", d, 32'd7);
    check("R12 read of count", d, 32'd7);
    tick_i = 1'b1;
    reg_wr(3'd0, 32'h0);
    reg_rd(3'd1, d);
    repeat (5) @(negedge clk);
    reg_rd(3'd1, d2);
    tick_i = 1'b0;
    check("R2 count frozen after stop", d2, d);
  endtask

  task automatic t_prescale();
    logic [W-1:0] d;
    reg_wr(3'd1, 32'd0);
    reg_wr(3'd0, 32'h25);
    ticks(8);
    reg_rd(3'd1, d);
    check("R4 divide by 4", d, 32'd2);
    reg_wr(3'd0, 32'h21);
    reg_wr(3'd1, 32'd0);
    ticks(6);
    reg_rd(3'd1, d);
    check("R4 divide by 2", d, 32'd3);
    reg_wr(3'd0, 32'h0);
  endtask

  task automatic t_match();
    logic [W-1:0] d;
    int m0;
    reg_wr(3'd1, 32'd0);
    reg_wr(3'd4, 32'd5);
    m0 = n_match;
    reg_wr(3'd0, 32'h41);
    ticks(5);
    check("R5 match event at match value", W'(evt_o[0]), 32'd1);
    ticks(1);
    check("R5 match event is one cycle", W'(evt_o[0]), 32'd0);
    check("R5 one match event", W'(n_match - m0), 32'd1);
    reg_wr(3'd1, 32'd0);
    reg_wr(3'd0, 32'h1);
    ticks(6);
    check("R5 no match event when compare off", W'(n_match - m0), 32'd1);
    reg_wr(3'd0, 32'h0);
  endtask

  task automatic t_overflow();
    logic [W-1:0] d;
    reg_wr(3'd2, 32'd100);
    reg_wr(3'd1, 32'hFFFF_FFFE);
    reg_wr(3'd0, 32'h3);
    ticks(2);
    check("R3 overflow event with reload", W'(evt_o[1]), 32'd1);
    reg_rd(3'd1, d);
    check("R3 count reloaded", d, 32'd100);
    reg_rd(3'd0, d);
    check("R3 run kept with reload", d & 32'h1, 32'h1);
    reg_wr(3'd1, 32'hFFFF_FFFF);
    reg_wr(3'd0, 32'h1);
    ticks(1);
    check("R3 overflow event one-shot", W'(evt_o[1]), 32'd1);
    ticks(3);
    reg_rd(3'd1, d);
    check("R3 one-shot wraps to zero and stops", d, 32'd0);
    reg_rd(3'd0, d);
    check("R3 run bit cleared", d, 32'h0);
  endtask

  task automatic t_trigger();
    logic [W-1:0] d;
    reg_wr(3'd0, 32'h0);
    reg_wr(3'd2, 32'h55);
    reg_wr(3'd1, 32'd7);
    reg_wr(3'd3, 32'hDEAD);
    reg_rd(3'd1, d);
    check("R6 trigger write loads count", d, 32'h55);
  endtask

  task automatic t_capture();
    logic [W-1:0] d;
    int c0;
    reg_wr(3'd0, 32'h100);
    reg_wr(3'd1, 32'd1000);
    c0 = n_cap;
    cap_pin_i = 1'b1;
    repeat (3) @(negedge clk);
    check("R7 capture event three edges after pin", W'(evt_o[2]), 32'd1);
    repeat (2) @(negedge clk);
    reg_rd(3'd5, d);
    check("R7 rising capture value", d, 32'd1000);
    reg_wr(3'd1, 32'd2000);
    pin_to(1'b0);
    check("R7 falling ignored in rising mode", W'(n_cap - c0), 32'd1);
    reg_wr(3'd0, 32'h300);
    pin_to(1'b1);
    reg_rd(3'd5, d);
    check("R7 both edges rising", d, 32'd2000);
    reg_wr(3'd1, 32'd3000);
    pin_to(1'b0);
    reg_rd(3'd5, d);
    check("R7 both edges falling", d, 32'd3000);
    reg_wr(3'd0, 32'h200);
    reg_wr(3'd1, 32'd4000);
    pin_to(1'b1);
    reg_rd(3'd5, d);
    check("R7 rising ignored in falling mode", d, 32'd3000);
    pin_to(1'b0);
    reg_rd(3'd5, d);
    check("R7 falling capture", d, 32'd4000);
  endtask

  task automatic t_dual();
    logic [W-1:0] d;
    reg_wr(3'd0, 32'h2100);
    reg_wr(3'd1, 32'd10); pin_to(1'b1); pin_to(1'b0);
    reg_wr(3'd1, 32'd20); pin_to(1'b1); pin_to(1'b0);
    reg_wr(3'd1, 32'd30); pin_to(1'b1); pin_to(1'b0);
    reg_rd(3'd5, d);
    check("R8 first edge to capture 1", d, 32'd10);
    reg_rd(3'd6, d);
    check("R8 second edge to capture 2", d, 32'd20);
    reg_wr(3'd0, 32'h2100);
    reg_wr(3'd1, 32'd40); pin_to(1'b1); pin_to(1'b0);
    reg_rd(3'd5, d);
    check("R8 rearm by control write", d, 32'd40);
    reg_wr(3'd0, 32'h0);
  endtask

  task automatic t_toggle();
    reg_wr(3'd2, 32'hFFFF_FFFD);
    reg_wr(3'd1, 32'hFFFF_FFFD);
    reg_wr(3'd4, 32'hFFFF_FFFE);
    reg_wr(3'd0, 32'h1843);
    check("R9 output starts at idle", W'(pwm_o), 32'd0);
    ticks(1);
    check("R9 toggle on match", W'(pwm_o), 32'd1);
    ticks(1);
    check("R9 no toggle without event", W'(pwm_o), 32'd1);
    ticks(1);
    check("R9 toggle on overflow", W'(pwm_o), 32'd0);
    reg_wr(3'd0, 32'h0);
  endtask

  task automatic t_pulse();
    reg_wr(3'd2, 32'd0);
    reg_wr(3'd1, 32'hFFFF_FFFF);
    reg_wr(3'd0, 32'h403);
    ticks(1);
    check("R10 pulse starts on overflow", W'(pwm_o), 32'd1);
    repeat (3) @(negedge clk);
    check("R10 pulse held until next tick", W'(pwm_o), 32'd1);
    ticks(1);
    check("R10 pulse ends at next tick", W'(pwm_o), 32'd0);
    reg_wr(3'd0, 32'h0);
  endtask

  task automatic t_idle();
    reg_wr(3'd0, 32'h80);
    @(negedge clk);
    check("R11 idle level high while stopped", W'(pwm_o), 32'd1);
    reg_wr(3'd0, 32'h0);
    @(negedge clk);
    check("R11 idle level low while stopped", W'(pwm_o), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_count_stop();
    t_prescale();
    t_match();
    t_overflow();
    t_trigger();
    t_capture();
    t_dual();
    t_toggle();
    t_pulse();
    t_idle();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule